// File: doc/BRIEF.md
# Write-Protect and Status Controller

This unit sits beside the command decoder of a small serial nonvolatile memory. It holds the status byte that a status-read command returns and decides, at the instant a write or status-write command is committed, whether the memory may start programming. The decision depends on four things. The first is a volatile enable latch that software sets and clears with single-cycle command pulses. The second is a hardware protect pin. The third is a two-bit protection field that fences off the upper quarter, the upper half or all of the array. The fourth is whether a previous programming cycle is still running.

A granted commit starts a self-timed busy period, a fixed count of system clocks, and drops the enable latch. A status-write commit loads the new protection field, but the field only takes effect when the busy period ends. The protection field models nonvolatile storage: only the power-on reset clears it, and the warm reset leaves it untouched.

Top module: `wprot_status_unit`

## Requirements
- R1: The status byte reads, from bit 7 to bit 0: 1, 1, 1, 1, protect bit 1, protect bit 0, enable latch, busy. After power-on reset it is F0h.
- R2: A set pulse raises the enable latch and a clear pulse lowers it. When both arrive in one cycle, the latch ends low.
- R3: A commit that arrives while the enable latch is 0 is denied. It starts no busy period and changes no status bit.
- R4: A granted write or status-write commit clears the enable latch in the same update that starts the busy period.
- R5: A granted status-write takes only data bits 3 and 2 as the new protection field. The field changes on the clock edge that ends the busy period, and the status byte shows the old field until then.
- R6: After a grant, busy stays 1 for exactly BUSY_CYCLES clock cycles. While busy, every commit is denied and the set and clear pulses have no effect.
- R7: With the protect pin low, both kinds of commit are denied. When the unit is idle and the pin is low while a command is open or at a commit, the enable latch clears. This has priority over a set pulse in the same cycle.
- R8: While busy, the protect pin has no effect. The running cycle ends on time and still applies its protection field.
- R9: With the protection field at 00, nothing is protected. At 01, addresses 60h-7Fh are protected. At 10, 40h-7Fh. At 11, the whole array. A write commit to a protected address is denied. The range check does not apply to a status-write commit.
- R10: The warm reset clears the enable latch and stops a running busy period, and it keeps the protection field. The power-on reset also clears the protection field to 00.
- R11: Grant and deny are single-cycle pulses. They are valid in the cycle after the commit cycle, and they are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; clears all state |
| rst_n | input | 1 | Warm reset, active low, synchronous; keeps the protection field |
| cmd_open | input | 1 | A write or status-write command is being shifted in |
| wren_pulse | input | 1 | Set-enable command pulse |
| wrdi_pulse | input | 1 | Clear-enable command pulse |
| wr_commit | input | 1 | Array write commit request |
| wr_addr | input | ADDR_W | Target address of the array write |
| wrsr_commit | input | 1 | Status-write commit request |
| wrsr_data | input | 8 | Status-write data byte |
| wp_n | input | 1 | Write-protect pin, active low |
| status_byte | output | 8 | Status byte for a status read |
| wr_grant | output | 1 | Commit accepted, programming started |
| wr_deny | output | 1 | Commit refused |
| busy | output | 1 | Self-timed programming in progress |

## Verification
Several decisions can land on the same clock edge, and the bench provokes each of them on purpose.

- **Set and clear pulses together.** Both are driven in one cycle, and the latch must end low.
- **Protect pin and a command.** The protect pin drops in the same cycle as an open command or a commit. The bench judges the result from the deny pulse and from the enable bit of the status byte.
- **End of busy and the protection field.** The end of the busy period coincides with the protection field update. The bench reads the status byte one cycle before the expected end and again at it, so an early or late update shows as a wrong byte.
- **Busy and the protect pin.** The pin is held low across a busy period. That period must still run its full length and then load its field.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

    typedef enum logic [1:0] {
        PROT_NONE = 2'b00,
        PROT_QTR  = 2'b01,
        PROT_HALF = 2'b10,
        PROT_ALL  = 2'b11
    } prot_mode_e;

    typedef struct packed {
        logic       wen;
        logic [1:0] bp;
        logic [1:0] bp_pend;
        logic       pend_vld;
        logic       grant;
        logic       deny;
    } ctl_state_t;

    localparam ctl_state_t CTL_RST = '{
        wen: 1'b0, bp: 2'b00, bp_pend: 2'b00,
        pend_vld: 1'b0, grant: 1'b0, deny: 1'b0
    };

    localparam int unsigned STATUS_W = 8;
    localparam int unsigned BP_LSB   = 2;

endpackage

// File: rtl/wprot_range_dec.sv
module wprot_range_dec
    import wprot_pkg::*;
#(
    parameter int unsigned ADDR_W = 7
) (
    input  prot_mode_e        mode,
    input  logic [ADDR_W-1:0] addr,
    output logic              locked
);
    localparam int unsigned TOP = ADDR_W - 1;

    always_comb begin
        unique case (mode)
            PROT_NONE: locked = 1'b0;
            PROT_QTR:  locked = addr[TOP] & addr[TOP-1];
            PROT_HALF: locked = addr[TOP];
            PROT_ALL:  locked = 1'b1;
            default:   locked = 1'b1;
        endcase
    end
endmodule

// File: rtl/wprot_busy_timer.sv
module wprot_busy_timer #(
    parameter int unsigned BUSY_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int unsigned CNT_W = $clog2(BUSY_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(BUSY_CYCLES - 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.busy) begin
            if (tmr_q.cnt == '0) tmr_d.busy = 1'b0;
            else                 tmr_d.cnt  = tmr_q.cnt - 1'b1;
        end else if (start) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = LOAD;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign busy = tmr_q.busy;
    assign done = tmr_q.busy && (tmr_q.cnt == '0);

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.busy |-> (tmr_q.cnt < CNT_W'(BUSY_CYCLES)));

    // R6
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !tmr_q.busy);
endmodule

// File: rtl/wprot_status_unit.sv
module wprot_status_unit
    import wprot_pkg::*;
#(
    parameter int unsigned ADDR_W      = 7,
    parameter int unsigned BUSY_CYCLES = 20
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              cmd_open,
    input  logic              wren_pulse,
    input  logic              wrdi_pulse,
    input  logic              wr_commit,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wrsr_commit,
    input  logic [7:0]        wrsr_data,
    input  logic              wp_n,
    output logic [7:0]        status_byte,
    output logic              wr_grant,
    output logic              wr_deny,
    output logic              busy
);
    ctl_state_t ctl_d, ctl_q, ctl_warm;

    logic locked;
    logic done;
    logic tmr_rst_n;
    logic idle;
    logic commit_any;
    logic allow;
    logic wp_kill;
    logic grant_now;

    assign tmr_rst_n = por_n & rst_n;

    wprot_range_dec #(.ADDR_W(ADDR_W)) u_range (
        .mode   (prot_mode_e'(ctl_q.bp)),
        .addr   (wr_addr),
        .locked (locked)
    );

    wprot_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (tmr_rst_n),
        .start (grant_now),
        .busy  (busy),
        .done  (done)
    );

    always_comb begin
        idle       = !busy;
        commit_any = wr_commit | wrsr_commit;
        allow      = idle && ctl_q.wen && wp_n && (wrsr_commit || !locked);
        grant_now  = commit_any && allow;
        wp_kill    = idle && !wp_n && (cmd_open || commit_any);
    end

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.grant = grant_now;
        ctl_d.deny  = commit_any && !allow;

        if (idle) begin
            if (wren_pulse) ctl_d.wen = 1'b1;
            if (wrdi_pulse) ctl_d.wen = 1'b0;
            if (wp_kill)    ctl_d.wen = 1'b0;
        end

        if (grant_now) begin
            ctl_d.wen = 1'b0;
            if (wrsr_commit) begin
                ctl_d.bp_pend  = wrsr_data[BP_LSB+1:BP_LSB];
                ctl_d.pend_vld = 1'b1;
            end
        end

        if (done && ctl_q.pend_vld) begin
            ctl_d.bp       = ctl_q.bp_pend;
            ctl_d.pend_vld = 1'b0;
        end

        ctl_warm    = CTL_RST;
        ctl_warm.bp = ctl_q.bp;
    end

    always_ff @(posedge clk) begin
        if (!por_n)      ctl_q <= CTL_RST;
        else if (!rst_n) ctl_q <= ctl_warm;
        else             ctl_q <= ctl_d;
    end

    assign status_byte = {4'b1111, ctl_q.bp, ctl_q.wen, busy};
    assign wr_grant    = ctl_q.grant;
    assign wr_deny     = ctl_q.deny;

    // R4
    wen_clear_on_grant_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        ctl_q.grant |-> (!ctl_q.wen && busy));

    // R3
    deny_no_busy_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (ctl_q.deny && !$past(busy)) |-> !busy);

    // R6
    busy_rise_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        $rose(busy) |-> ctl_q.grant);

    // R5
    bp_hold_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        !$past(done) |-> $stable(ctl_q.bp));

    // R11
    grant_deny_excl_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        !(ctl_q.grant && ctl_q.deny));

    // R7
    wp_kill_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (!busy && !wp_n && cmd_open) |=> !ctl_q.wen);
endmodule

// File: tb/sim_wprot_status_unit.sv
module sim_wprot_status_unit;
    localparam int NB = 20;

    logic       clk = 1'b0;
    logic       por_n = 1'b0, rst_n = 1'b1, cmd_open = 1'b0;
    logic       wren_pulse = 1'b0, wrdi_pulse = 1'b0;
    logic       wr_commit = 1'b0, wrsr_commit = 1'b0, wp_n = 1'b1;
    logic [6:0] wr_addr = '0;
    logic [7:0] wrsr_data = '0;
    logic [7:0] status_byte;
    logic       wr_grant, wr_deny, busy;

    int vecs = 0, miss = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    wprot_status_unit #(.ADDR_W(7), .BUSY_CYCLES(NB)) u0 (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .cmd_open(cmd_open),
        .wren_pulse(wren_pulse), .wrdi_pulse(wrdi_pulse),
        .wr_commit(wr_commit), .wr_addr(wr_addr),
        .wrsr_commit(wrsr_commit), .wrsr_data(wrsr_data), .wp_n(wp_n),
        .status_byte(status_byte), .wr_grant(wr_grant), .wr_deny(wr_deny), .busy(busy)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        vecs++;
        if (act !== exp) begin
            miss++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic pulse_wren();
        wren_pulse = 1'b1; step(); wren_pulse = 1'b0;
    endtask

    task automatic pulse_wrdi();
        wrdi_pulse = 1'b1; step(); wrdi_pulse = 1'b0;
    endtask

    task automatic do_write(input logic [6:0] a);
        wr_commit = 1'b1; wr_addr = a; step(); wr_commit = 1'b0;
    endtask

    task automatic do_wrsr(input logic [7:0] d);
        wrsr_commit = 1'b1; wrsr_data = d; step(); wrsr_commit = 1'b0;
    endtask

    task automatic wait_idle();
        repeat (NB) step();
    endtask

    task automatic set_bp(input logic [7:0] d, input logic [7:0] exp_stat);
        pulse_wren(); do_wrsr(d);
        chk("R5 wrsr grant", {7'b0, wr_grant}, 8'h01);
        wait_idle();
        chk("R5 bp applied", status_byte, exp_stat);
    endtask

    task automatic t_reset();
        chk("R1 reset status", status_byte, 8'hF0);
        chk("R1 reset busy", {7'b0, busy}, 8'h00);
        chk("R11 reset grant/deny", {6'b0, wr_grant, wr_deny}, 8'h00);
    endtask

    task automatic t_enable();
        pulse_wren();  chk("R2 set", status_byte, 8'hF2);
        pulse_wrdi();  chk("R2 clear", status_byte, 8'hF0);
        pulse_wren();  chk("R2 set again", status_byte, 8'hF2);
        wren_pulse = 1'b1; wrdi_pulse = 1'b1; step();
        wren_pulse = 1'b0; wrdi_pulse = 1'b0;
        chk("R2 both pulses", status_byte, 8'hF0);
    endtask

    task automatic t_no_wen();
        do_write(7'h00);
        chk("R3 deny", {6'b0, wr_grant, wr_deny}, 8'h01);
        chk("R3 status", status_byte, 8'hF0);
        step();
        chk("R3 no busy", {7'b0, busy}, 8'h00);
        chk("R11 deny one cycle", {7'b0, wr_deny}, 8'h00);
    endtask

    task automatic t_write();
        pulse_wren();
        do_write(7'h10);
        chk("R11 grant", {6'b0, wr_grant, wr_deny}, 8'h02);
        chk("R4 wen cleared, busy", status_byte, 8'hF1);
        pulse_wren();
        chk("R6 set ignored while busy", status_byte, 8'hF1);
        chk("R11 grant one cycle", {7'b0, wr_grant}, 8'h00);
        do_write(7'h11);
        chk("R6 commit denied while busy", {6'b0, wr_grant, wr_deny}, 8'h01);
        repeat (NB - 3) step();
        chk("R6 still busy at last cycle", {7'b0, busy}, 8'h01);
        step();
        chk("R6 busy ends", status_byte, 8'hF0);
    endtask

    task automatic t_wrsr();
        pulse_wren();
        do_wrsr(8'hF7);
        chk("R5 grant", {7'b0, wr_grant}, 8'h01);
        chk("R5 old bp during busy", status_byte, 8'hF1);
        repeat (NB - 1) step();
        chk("R5 old bp at last busy cycle", status_byte, 8'hF1);
        step();
        chk("R5 only bits 3:2 taken", status_byte, 8'hF4);
    endtask

    task automatic t_protect();
        pulse_wren();
        do_write(7'h60);
        chk("R9 qtr deny 60h", {6'b0, wr_grant, wr_deny}, 8'h01);
        chk("R9 deny keeps wen", status_byte, 8'hF6);
        do_write(7'h5F);
        chk("R9 qtr grant 5Fh", {6'b0, wr_grant, wr_deny}, 8'h02);
        wait_idle();
        set_bp(8'h08, 8'hF8);
        pulse_wren();
        do_write(7'h40);
        chk("R9 half deny 40h", {6'b0, wr_grant, wr_deny}, 8'h01);
        do_write(7'h3F);
        chk("R9 half grant 3Fh", {6'b0, wr_grant, wr_deny}, 8'h02);
        wait_idle();
        set_bp(8'h0C, 8'hFC);
        pulse_wren();
        do_write(7'h00);
        chk("R9 all deny 00h", {6'b0, wr_grant, wr_deny}, 8'h01);
        pulse_wrdi();
        chk("R9 status after", status_byte, 8'hFC);
    endtask

    task automatic t_wp();
        pulse_wren();
        chk("R7 wen set", status_byte, 8'hFE);
        cmd_open = 1'b1; wp_n = 1'b0; wren_pulse = 1'b1; step();
        cmd_open = 1'b0; wp_n = 1'b1; wren_pulse = 1'b0;
        chk("R7 pin clears latch over set", status_byte, 8'hFC);
        pulse_wren();
        wp_n = 1'b0; do_wrsr(8'h00); wp_n = 1'b1;
        chk("R7 wrsr denied by pin", {6'b0, wr_grant, wr_deny}, 8'h01);
        chk("R7 status after pin deny", status_byte, 8'hFC);
        pulse_wren();
        wp_n = 1'b0; do_write(7'h00); wp_n = 1'b1;
        chk("R7 write denied by pin", {6'b0, wr_grant, wr_deny}, 8'h01);
    endtask

    task automatic t_wp_busy();
        pulse_wren();
        do_wrsr(8'h00);
        chk("R8 grant", {7'b0, wr_grant}, 8'h01);
        wp_n = 1'b0; cmd_open = 1'b1;
        repeat (NB - 1) step();
        chk("R8 busy unaffected by pin", {7'b0, busy}, 8'h01);
        step();
        chk("R8 bp applied despite pin", status_byte, 8'hF0);
        wp_n = 1'b1; cmd_open = 1'b0;
    endtask

    task automatic t_resets();
        set_bp(8'h04, 8'hF4);
        pulse_wren();
        chk("R10 pre warm", status_byte, 8'hF6);
        rst_n = 1'b0; step(); rst_n = 1'b1;
        chk("R10 warm keeps bp", status_byte, 8'hF4);
        pulse_wren();
        do_write(7'h00);
        chk("R10 grant before reset", status_byte, 8'hF5);
        rst_n = 1'b0; step(); rst_n = 1'b1;
        chk("R10 warm stops busy", status_byte, 8'hF4);
        por_n = 1'b0; step(); por_n = 1'b1;
        chk("R10 por clears bp", status_byte, 8'hF0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            miss++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
            $finish;
        end
    end

    initial begin
        step(); step();
        por_n = 1'b1;
        step();
        t_reset();
        t_enable();
        t_no_wen();
        t_write();
        t_wrsr();
        t_protect();
        t_wp();
        t_wp_busy();
        t_resets();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    end
endmodule